// File: doc/BRIEF.md
# Matrix Keyboard Scanner with Key Queue

This block walks a key matrix one row at a time and turns debounced key closures into byte-wide key events held in a small first-in first-out queue. A row counter, advanced by an external scan-rate strobe, is presented on the scan outputs; external logic or a decoder uses it to energise one matrix row. The block then samples the eight return (column) lines for that row. A key is accepted only when it has read closed on two successive visits of its row. Each accepted key becomes a byte that holds its row and column together with the shift and control levels seen at that moment.

Events enter an eight-entry queue. An interrupt stays high while the queue holds anything, and the host removes entries through a pop input while the oldest entry is always visible on the data output. A selectable policy governs simultaneous presses. Two-key lockout admits a single held key at a time. N-key rollover admits every held key, one per row visit. A queue-clear input empties the queue and drops the interrupt.

Top module: `keyscan_top`

## Requirements
- R1: After reset the scan output is 0, the queue is empty, `irq` is low and `overrun` is low.
- R2: Every cycle with `scan_tick` high advances `scan_line` by one row, wrapping from ROWS-1 to 0; without `scan_tick` it holds.
- R3: A return line reads 1 for a closed key. A key is queued only after it reads closed on two consecutive visits of its row; a closure seen on a single visit is never queued.
- R4: The key byte is bit 7 = control, bit 6 = shift, bits 5:3 = row, bits 2:0 = column, with `ctrl_in` and `shift_in` taken in the cycle the key is queued.
- R5: A queued key is not queued again until a visit of its row has seen it released.
- R6: With `nkro_mode` low (two-key lockout), no key is queued while any previously queued key is still held; of several keys confirmed on the same visit only the lowest column is queued.
- R7: With `nkro_mode` high (N-key rollover), every held key is queued on its own, at most one per row visit, lowest column first within a row.
- R8: The queue holds 8 entries in arrival order; `key_data` shows the oldest; `pop` removes it when the queue is not empty and has no effect on an empty queue.
- R9: `irq` is high exactly when `fifo_count` is nonzero.
- R10: A key queued while the queue already holds 8 entries is dropped, the stored entries are kept, and `overrun` goes high and stays high until a clear or reset.
- R11: `fifo_clear` empties the queue, lowers `irq` and `overrun`, and takes priority over a push or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_tick | input | 1 | Scan-rate strobe: sample the current row and step to the next |
| ret_in | input | COLS | Return lines of the current row, 1 = closed |
| shift_in | input | 1 | Shift level stored with a key |
| ctrl_in | input | 1 | Control level stored with a key |
| nkro_mode | input | 1 | 0 = two-key lockout, 1 = N-key rollover |
| pop | input | 1 | Remove the oldest queued byte |
| fifo_clear | input | 1 | Empty the queue and clear the overrun flag |
| scan_line | output | SCAN_W | Row currently scanned |
| key_data | output | 8 | Oldest queued key byte |
| fifo_count | output | $clog2(DEPTH+1) | Number of queued bytes |
| irq | output | 1 | High while the queue is not empty |
| overrun | output | 1 | Sticky flag: a key was dropped on a full queue |

## Verification
The assertions take for granted that `ret_in` reflects the row named by `scan_line` in the same cycle, settling combinationally before the sampling edge, and that `scan_tick`, `pop` and `fifo_clear` are single-cycle synchronous levels. The bench meets this by deriving the return lines from its own key array with a continuous assignment indexed by `scan_line`, and by changing every input one nanosecond after the rising edge. Random key presses are kept sparse so that debouncing, lockout and rollover all occur, and mode changes and clears land at arbitrary points.

// File: rtl/keyscan_pkg.sv
`timescale 1ns/1ps
package keyscan_pkg;
  // Key byte field widths; the byte layout is fixed at 8 bits
  localparam int KEY_ROW_W = 3;
  localparam int KEY_COL_W = 3;

  typedef logic [7:0] key_byte_t;

  // Layout: control, shift, row, column (MSB to LSB)
  function automatic key_byte_t pack_key(input logic ctrl, input logic shift,
                                         input logic [KEY_ROW_W-1:0] row,
                                         input logic [KEY_COL_W-1:0] col);
    return {ctrl, shift, row, col};
  endfunction

  // Next index of a circular pointer over 'depth' slots
  function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/keyscan_rowctr.sv
`timescale 1ns/1ps
module keyscan_rowctr #(
  parameter int ROWS = 8,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [ROW_W-1:0] row
);
  import keyscan_pkg::*;

  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst) row_q <= '0;
    else if (tick) row_q <= ROW_W'(wrap_inc(int'(row_q), ROWS));
  end

  assign row = row_q;

  // R2: one row per strobe, wrapping at the last row
  a_r2_row_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> (row_q == (($past(row_q) == ROW_W'(ROWS-1)) ? '0 : $past(row_q) + 1'b1)));
  // R2: no strobe, no movement
  a_r2_row_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(row_q));
endmodule

// File: rtl/keyscan_debounce.sv
`timescale 1ns/1ps
module keyscan_debounce #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [ROW_W-1:0] row,
  input  logic [COLS-1:0]  ret,
  input  logic             nkro,
  output logic             hit,
  output logic [COL_W-1:0] hit_col
);
  // Per key: closed on the previous visit, and already queued
  logic [COLS-1:0] seen_q [ROWS];
  logic [COLS-1:0] rep_q  [ROWS];

  logic [COLS-1:0] fresh;
  logic [COLS-1:0] grant_mask;
  logic            any_rep;
  logic            lockout;
  logic            found;

  function automatic logic [COL_W-1:0] lowest_set(input logic [COLS-1:0] v);
    logic [COL_W-1:0] idx;
    idx = '0;
    for (int i = COLS - 1; i >= 0; i--) if (v[i]) idx = COL_W'(i);
    return idx;
  endfunction

  always_comb begin
    any_rep = 1'b0;
    for (int r = 0; r < ROWS; r++) any_rep = any_rep | (|rep_q[r]);
  end

  assign fresh      = ret & seen_q[row] & ~rep_q[row];
  assign found      = |fresh;
  assign lockout    = !nkro && any_rep;
  assign hit        = tick && found && !lockout;
  assign hit_col    = lowest_set(fresh);
  assign grant_mask = hit ? (COLS'(1) << hit_col) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) begin
        seen_q[r] <= '0;
        rep_q[r]  <= '0;
      end
    end else if (tick) begin
      seen_q[row] <= ret;
      rep_q[row]  <= (rep_q[row] & ret) | grant_mask;
    end
  end

  // R5: a granted key is marked reported on the following cycle
  a_r5_mark_after_grant: assert property (@(posedge clk) disable iff (rst)
    hit |=> rep_q[$past(row)][$past(hit_col)]);
endmodule

// File: rtl/keyscan_fifo.sv
`timescale 1ns/1ps
module keyscan_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  input  logic             clr,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             ovr
);
  import keyscan_pkg::*;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovr_q;
  logic             full, empty, push_ok, pop_ok;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (push_ok) wr_q <= PTR_W'(wrap_inc(int'(wr_q), DEPTH));
      if (pop_ok)  rd_q <= PTR_W'(wrap_inc(int'(rd_q), DEPTH));
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
      if (push && full) ovr_q <= 1'b1;
    end
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;
  assign ovr   = ovr_q;

  // R8: occupancy never exceeds the depth
  a_r8_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));
  // R8: popping an empty queue with no push leaves it empty
  a_r8_pop_empty: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push && !clr) |=> (cnt_q == '0));
  // R10: push on a full queue is dropped and raises the flag
  a_r10_drop_full: assert property (@(posedge clk) disable iff (rst)
    (push && full && !clr) |=> (ovr_q && cnt_q == $past(cnt_q) - CNT_W'($past(pop))));
endmodule

// File: rtl/keyscan_top.sv
`timescale 1ns/1ps
module keyscan_top #(
  parameter int ROWS   = 8,
  parameter int COLS   = 8,
  parameter int DEPTH  = 8,
  parameter int SCAN_W = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         scan_tick,
  input  logic [COLS-1:0]              ret_in,
  input  logic                         shift_in,
  input  logic                         ctrl_in,
  input  logic                         nkro_mode,
  input  logic                         pop,
  input  logic                         fifo_clear,
  output logic [SCAN_W-1:0]            scan_line,
  output logic [7:0]                   key_data,
  output logic [$clog2(DEPTH+1)-1:0]   fifo_count,
  output logic                         irq,
  output logic                         overrun
);
  import keyscan_pkg::*;

  // ROWS and COLS are limited to 8 each by the 3-bit key byte fields
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;

  logic [ROW_W-1:0] row;
  logic             key_hit;
  logic [COL_W-1:0] key_col;
  key_byte_t        key_byte;

  keyscan_rowctr #(.ROWS(ROWS)) u_rowctr (
    .clk(clk), .rst(rst), .tick(scan_tick), .row(row)
  );

  keyscan_debounce #(.ROWS(ROWS), .COLS(COLS)) u_debounce (
    .clk(clk), .rst(rst), .tick(scan_tick), .row(row), .ret(ret_in),
    .nkro(nkro_mode), .hit(key_hit), .hit_col(key_col)
  );

  assign key_byte = pack_key(ctrl_in, shift_in, KEY_ROW_W'(row), KEY_COL_W'(key_col));

  keyscan_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst(rst), .push(key_hit), .din(key_byte), .pop(pop),
    .clr(fifo_clear), .head(key_data), .count(fifo_count), .ovr(overrun)
  );

  assign scan_line = SCAN_W'(row);
  assign irq       = (fifo_count != '0);

  // R11: a clear empties the queue and drops both flags
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    fifo_clear |=> (fifo_count == '0 && !irq && !overrun));
  // R3: a queued key reads closed on the return lines at that moment
  a_r3_key_closed: assert property (@(posedge clk) disable iff (rst)
    key_hit |-> ret_in[key_col]);
endmodule

// File: tb/keyscan_top_bench.sv
`timescale 1ns/1ps
module keyscan_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scan_tick = 1'b0, shift_in = 1'b0, ctrl_in = 1'b0;
  logic       nkro_mode = 1'b0, pop = 1'b0, fifo_clear = 1'b0;
  logic [63:0] pressed = '0;
  logic [7:0] ret_in;
  logic [3:0] scan_line;
  logic [7:0] key_data;
  logic [3:0] fifo_count;
  logic       irq, overrun;

  int checks = 0, errors = 0;

  // reference state
  int        m_row;
  bit [63:0] m_seen, m_rep;
  bit [7:0]  m_q[$];
  bit        m_ovr;

  always #2.5 clk = ~clk;

  assign ret_in = pressed[{scan_line[2:0], 3'b000} +: 8];

  keyscan_top u_keyscan_top (
    .clk(clk), .rst(rst), .scan_tick(scan_tick), .ret_in(ret_in),
    .shift_in(shift_in), .ctrl_in(ctrl_in), .nkro_mode(nkro_mode), .pop(pop),
    .fifo_clear(fifo_clear), .scan_line(scan_line), .key_data(key_data),
    .fifo_count(fifo_count), .irq(irq), .overrun(overrun)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected byte: ctrl, shift, row, column
  function automatic bit [7:0] kb(input bit c, input bit s, input int r, input int col);
    return {c, s, 3'(r), 3'(col)};
  endfunction

  // Advance the reference by one clock using the inputs now applied
  task automatic model_step();
    bit push_ev; bit [7:0] nb; bit full_before; bit anyrep;
    push_ev = 0; nb = '0;
    if (scan_tick) begin
      anyrep = (m_rep != 0);
      for (int c = 0; c < 8; c++) begin
        int k = m_row * 8 + c;
        if (!push_ev && pressed[k] && m_seen[k] && !m_rep[k] && (nkro_mode || !anyrep)) begin
          push_ev = 1; nb = kb(ctrl_in, shift_in, m_row, c); m_rep[k] = 1;
        end
      end
      for (int c = 0; c < 8; c++) begin
        int k = m_row * 8 + c;
        m_seen[k] = pressed[k];
        if (!pressed[k]) m_rep[k] = 0;
      end
      m_row = (m_row + 1) % 8;
    end
    full_before = (m_q.size() == 8);
    if (fifo_clear) begin
      m_q.delete(); m_ovr = 0;
    end else begin
      if (pop && m_q.size() > 0) void'(m_q.pop_front());
      if (push_ev) begin
        if (full_before) m_ovr = 1; else m_q.push_back(nb);
      end
    end
  endtask

  task automatic compare();
    check("R2 scan_line", scan_line, m_row);
    check("R8 fifo_count", fifo_count, m_q.size());
    check("R9 irq", irq, m_q.size() != 0);
    check("R10 overrun", overrun, m_ovr);
    if (m_q.size() != 0) check("R4 key_data", key_data, m_q[0]);
  endtask

  task automatic step(input bit t, input bit p, input bit cl);
    scan_tick = t; pop = p; fifo_clear = cl;
    model_step();
    @(posedge clk); #1;
    compare();
    scan_tick = 0; pop = 0; fifo_clear = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0);
  endtask

  task automatic wait_row(input int r);
    while (m_row != r) step(1, 0, 0);
  endtask

  task automatic settle_empty();
    pressed = '0;
    ticks(16);
    step(0, 0, 1);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", wd);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd5150));
    m_row = 0; m_seen = '0; m_rep = '0; m_ovr = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: reset state
    check("R1 scan_line", scan_line, 0);
    check("R1 fifo_count", fifo_count, 0);
    check("R1 irq", irq, 0);
    check("R1 overrun", overrun, 0);

    // R3/R4: one key, shift held, two full scans
    nkro_mode = 0; shift_in = 1; ctrl_in = 0;
    wait_row(0);
    pressed[2*8+5] = 1;
    ticks(16);
    check("R3 two visits queue", fifo_count, 1);
    check("R4 byte layout", key_data, 8'h55);
    // R5: holding the key adds nothing
    ticks(24);
    check("R5 no repeat while held", fifo_count, 1);
    pressed[2*8+5] = 0; ticks(8);
    pressed[2*8+5] = 1; ctrl_in = 1; shift_in = 0; ticks(16);
    check("R5 requeue after release", fifo_count, 2);
    step(0, 1, 0);
    check("R4 ctrl captured", key_data, 8'h95);
    settle_empty();

    // R3: closure seen on one visit only
    wait_row(4);
    pressed[4*8+1] = 1; ticks(1); pressed[4*8+1] = 0;
    ticks(24);
    check("R3 single visit ignored", fifo_count, 0);

    // R11: clear with simultaneous pop
    wait_row(0);
    pressed[0] = 1; ticks(16); pressed[0] = 0;
    check("R11 setup", fifo_count, 1);
    step(1, 1, 1);
    check("R11 clear count", fifo_count, 0);
    check("R11 clear irq", irq, 0);
    settle_empty();

    // R6: lockout across rows
    shift_in = 0; ctrl_in = 0; nkro_mode = 0;
    wait_row(0);
    pressed[1*8+3] = 1; pressed[6*8+0] = 1;
    ticks(16);
    check("R6 first key only", fifo_count, 1);
    check("R6 first key byte", key_data, 8'h0B);
    ticks(16);
    check("R6 second key locked", fifo_count, 1);
    settle_empty();
    // R6: same row, lowest column
    wait_row(0);
    pressed[3*8+2] = 1; pressed[3*8+6] = 1;
    ticks(32);
    check("R6 same row count", fifo_count, 1);
    check("R6 same row lowest col", key_data, 8'h1A);
    settle_empty();

    // R7: rollover within one row
    nkro_mode = 1;
    wait_row(0);
    pressed[5*8+1] = 1; pressed[5*8+4] = 1; pressed[5*8+7] = 1;
    ticks(32);
    check("R7 all queued", fifo_count, 3);
    check("R7 order 0", key_data, 8'h29); step(0, 1, 0);
    check("R7 order 1", key_data, 8'h2C); step(0, 1, 0);
    check("R7 order 2", key_data, 8'h2F);
    settle_empty();

    // R10/R8: overflow, then drain in order
    wait_row(0);
    pressed[7:0] = 8'hFF; pressed[9:8] = 2'b11;
    ticks(96);
    check("R10 full count", fifo_count, 8);
    check("R10 overrun set", overrun, 1);
    begin
      bit [7:0] exp_list [8] = '{8'h00, 8'h08, 8'h01, 8'h09, 8'h02, 8'h03, 8'h04, 8'h05};
      for (int i = 0; i < 8; i++) begin
        check("R8 fifo order", key_data, exp_list[i]);
        step(0, 1, 0);
      end
    end
    check("R10 overrun sticky", overrun, 1);
    step(0, 1, 0);
    check("R8 pop on empty", fifo_count, 0);
    settle_empty();
    check("R11 overrun cleared", overrun, 0);

    // Random phase against the reference
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(19) == 0) pressed[$urandom_range(63)] ^= 1'b1;
      if ($urandom_range(799) == 0) nkro_mode = ~nkro_mode;
      shift_in = 1'($urandom_range(1));
      ctrl_in  = 1'($urandom_range(1));
      step($urandom_range(3) != 0, $urandom_range(5) == 0, $urandom_range(299) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule